// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block takes a small set of level-sensitive interrupt lines that belong to no single core and steers each one to the interrupt inputs of a group of cores. Every shared line has its own routing state: a core mask with one bit per core, a distribution select and a block bit. Software sets this state one line at a time through a single-cycle command port, where an opcode, a line number and a 32-bit data word are presented together with a valid strobe. A separate command switches the whole unit on or off. Until the unit is on, nothing reaches any core.

Two distribution schemes exist. The first is round-robin, which spreads load. Successive assertions of a shared line land on successive cores of its mask. The choice is held while the line stays high and moves on only after the line falls. The second is fixed-destination: the line always goes to the lowest-numbered core in its mask. Each core gets a separate output bit for every shared line. For any one line, at most one core sees it at a time.

Top module: `shared_irq_distributor`

## Requirements
- R1: After a synchronous reset every output is low, every line is blocked, every core mask is empty, every line is in round-robin mode with its pointer at core 0, and the unit is disabled.
- R2: Command opcode 0 (set destination) loads data bits [NUM_CORE-1:0] as the core mask of the line named by `cmd_irq`, where bit c stands for core c.
- R3: Command opcode 1 (set mode) takes its distribution select from data bits [1:0]. The value 00 selects round-robin and any other value selects fixed-destination. Bit 4 (level flag) and all other data bits have no effect on delivery, and every line is handled as level-sensitive.
- R4: Command opcode 2 (set block) blocks the named line when data bit 0 is 1 and unblocks it when bit 0 is 0. A blocked line drives all of its outputs low.
- R5: Command opcode 3 (global enable) turns the unit on when data bit 0 is 1 and off when it is 0. While the unit is off, every output is low.
- R6: In round-robin mode the chosen core is the first set mask bit at or after the line's pointer, searching upward with wrap-around. The choice stays fixed while the input is high. When the input falls while the mask is non-empty, the pointer moves to one past the chosen core, wrapping to 0.
- R7: In fixed-destination mode the line goes to the lowest-numbered core whose mask bit is set.
- R8: A line whose core mask is empty drives all of its outputs low.
- R9: Outputs are registered. The output after a clock edge reflects the input and state sampled at that edge, and for each line at most one core output is high.
- R10: Output bit `core_irq[c*NUM_IRQ + i]` carries line i to core c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | Opcode: 0 destination, 1 mode, 2 block, 3 global enable |
| cmd_irq | input | IRQ_W | Shared line addressed by the command |
| cmd_data | input | 32 | Command data word |
| irq_in | input | NUM_IRQ | Level-sensitive shared interrupt inputs |
| core_irq | output | NUM_CORE*NUM_IRQ | Per-core, per-line interrupt outputs |

## Verification
The hold property assumes that a line whose output is high keeps its routing state when no command arrived in the previous cycle. That holds because the pointer only moves on a falling input, and a falling input cannot coincide with a delivered output. The disabled-quiet property tracks the enable state from the command port alone, so the stimulus always addresses an existing line number. The random phase issues commands while inputs toggle, so that blocks, mask changes and mode changes mid-assertion are all exercised without ever naming a line outside the configured range.

// File: rtl/sid_pkg.sv
package sid_pkg;

    localparam int CMD_DATA_W = 32;
    localparam int MAX_CORES  = 32;

    typedef enum logic [1:0] {
        OP_SET_DEST  = 2'd0,
        OP_SET_MODE  = 2'd1,
        OP_SET_BLOCK = 2'd2,
        OP_ENABLE    = 2'd3
    } sid_op_e;

    localparam logic [1:0] DIST_RR = 2'b00;

    typedef struct packed {
        logic       hit;
        logic [4:0] idx;
    } sid_pick_t;

    // First set bit of mask at or after start, wrapping within n bits.
    function automatic sid_pick_t sid_pick(input logic [MAX_CORES-1:0] mask,
                                           input int unsigned n,
                                           input int unsigned start);
        sid_pick_t   r;
        int unsigned p;
        r = '0;
        for (int k = 0; k < MAX_CORES; k++) begin
            if (k < n && !r.hit) begin
                p = start + k;
                if (p >= n) p = p - n;
                if (mask[p[4:0]]) begin
                    r.hit = 1'b1;
                    r.idx = p[4:0];
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sid_cfg_bank.sv
module sid_cfg_bank
    import sid_pkg::*;
#(
    parameter int NUM_IRQ  = 4,
    parameter int NUM_CORE = 4,
    parameter int IRQ_W    = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cmd_valid,
    input  logic [1:0]                         cmd_op,
    input  logic [IRQ_W-1:0]                   cmd_irq,
    input  logic [CMD_DATA_W-1:0]              cmd_data,
    output logic                               unit_on,
    output logic [NUM_IRQ-1:0]                 blocked,
    output logic [NUM_IRQ-1:0]                 rr_sel,
    output logic [NUM_IRQ-1:0][NUM_CORE-1:0]   dest
);

    sid_op_e op;
    assign op = sid_op_e'(cmd_op);

    logic unused_data_bits;
    assign unused_data_bits = ^cmd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_on <= 1'b0;
        end else if (cmd_valid && op == OP_ENABLE) begin
            unit_on <= cmd_data[0];
        end
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        logic sel;
        assign sel = cmd_valid && (cmd_irq == IRQ_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                blocked[i] <= 1'b1;
                rr_sel[i]  <= 1'b1;
                dest[i]    <= '0;
            end else if (sel) begin
                case (op)
                    OP_SET_DEST:  dest[i]    <= cmd_data[NUM_CORE-1:0];
                    OP_SET_MODE:  rr_sel[i]  <= (cmd_data[1:0] == DIST_RR);
                    OP_SET_BLOCK: blocked[i] <= cmd_data[0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sid_lane.sv
module sid_lane
    import sid_pkg::*;
#(
    parameter int NUM_CORE = 4,
    parameter int CORE_W   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                unit_on,
    input  logic                blocked,
    input  logic                rr_sel,
    input  logic [NUM_CORE-1:0] dest,
    input  logic                level,
    output logic [NUM_CORE-1:0] lines
);

    logic [CORE_W-1:0]   ptr;
    logic                level_q;
    sid_pick_t           tgt;
    logic                deliver;
    logic                fall;
    logic [CORE_W-1:0]   ptr_next;
    logic [NUM_CORE-1:0] lines_d;

    always_comb begin
        tgt = sid_pick(MAX_CORES'(dest), NUM_CORE, rr_sel ? 32'(ptr) : 32'd0);
    end

    assign deliver = unit_on && !blocked && level && tgt.hit;
    assign fall    = level_q && !level;

    always_comb begin
        int nx;
        nx = int'(tgt.idx) + 1;
        if (nx >= NUM_CORE) nx = 0;
        ptr_next = CORE_W'(nx);
    end

    always_comb begin
        for (int c = 0; c < NUM_CORE; c++) begin
            lines_d[c] = deliver && (tgt.idx == 5'(c));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            level_q <= 1'b0;
            lines   <= '0;
        end else begin
            level_q <= level;
            lines   <= lines_d;
            if (rr_sel && fall && tgt.hit) begin
                ptr <= ptr_next;
            end
        end
    end

endmodule

// File: rtl/shared_irq_distributor.sv
module shared_irq_distributor
    import sid_pkg::*;
#(
    parameter int NUM_IRQ  = 4,
    parameter int NUM_CORE = 4,
    parameter int IRQ_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    input  logic [1:0]                   cmd_op,
    input  logic [IRQ_W-1:0]             cmd_irq,
    input  logic [CMD_DATA_W-1:0]        cmd_data,
    input  logic [NUM_IRQ-1:0]           irq_in,
    output logic [NUM_CORE*NUM_IRQ-1:0]  core_irq
);

    localparam int CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;

    logic                             unit_on;
    logic [NUM_IRQ-1:0]               blocked;
    logic [NUM_IRQ-1:0]               rr_sel;
    logic [NUM_IRQ-1:0][NUM_CORE-1:0] dest;

    sid_cfg_bank #(
        .NUM_IRQ  (NUM_IRQ),
        .NUM_CORE (NUM_CORE),
        .IRQ_W    (IRQ_W)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_irq   (cmd_irq),
        .cmd_data  (cmd_data),
        .unit_on   (unit_on),
        .blocked   (blocked),
        .rr_sel    (rr_sel),
        .dest      (dest)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lane
        logic [NUM_CORE-1:0] lines;

        sid_lane #(
            .NUM_CORE (NUM_CORE),
            .CORE_W   (CORE_W)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .unit_on (unit_on),
            .blocked (blocked[i]),
            .rr_sel  (rr_sel[i]),
            .dest    (dest[i]),
            .level   (irq_in[i]),
            .lines   (lines)
        );

        for (genvar c = 0; c < NUM_CORE; c++) begin : g_map
            assign core_irq[c*NUM_IRQ + i] = lines[c];
        end
    end

endmodule

// File: rtl/sid_checker.sv
module sid_checker #(
    parameter int NUM_IRQ  = 4,
    parameter int NUM_CORE = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cmd_valid,
    input logic [1:0]                  cmd_op,
    input logic                        cmd_bit0,
    input logic [NUM_IRQ-1:0]          irq_in,
    input logic [NUM_CORE*NUM_IRQ-1:0] core_irq
);

    logic en_shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_shadow <= 1'b0;
        end else if (cmd_valid && cmd_op == 2'd3) begin
            en_shadow <= cmd_bit0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> core_irq == '0);

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en_shadow |=> core_irq == '0);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        logic [NUM_CORE-1:0] col;
        always_comb begin
            for (int c = 0; c < NUM_CORE; c++) col[c] = core_irq[c*NUM_IRQ + i];
        end

        // R9
        single_core_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col));

        for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
            // R9
            needs_input_chk: assert property (@(posedge clk) disable iff (rst)
                core_irq[c*NUM_IRQ + i] |-> $past(irq_in[i]));

            // R6
            hold_target_chk: assert property (@(posedge clk) disable iff (rst)
                (core_irq[c*NUM_IRQ + i] && irq_in[i] && !$past(cmd_valid))
                |=> core_irq[c*NUM_IRQ + i]);
        end
    end

endmodule

bind shared_irq_distributor sid_checker #(
    .NUM_IRQ  (NUM_IRQ),
    .NUM_CORE (NUM_CORE)
) u_sid_checker (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bit0  (cmd_data[0]),
    .irq_in    (irq_in),
    .core_irq  (core_irq)
);

// File: tb/shared_irq_distributor_bench.sv
module shared_irq_distributor_bench;

    localparam int NI  = 4;
    localparam int NC  = 4;
    localparam int IW  = 2;
    localparam int TOT = NI * NC;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_valid = 1'b0;
    logic [1:0]      cmd_op = '0;
    logic [IW-1:0]   cmd_irq = '0;
    logic [31:0]     cmd_data = '0;
    logic [NI-1:0]   irq_in = '0;
    logic [TOT-1:0]  core_irq;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    shared_irq_distributor #(.NUM_IRQ(NI), .NUM_CORE(NC)) u_shared_irq_distributor (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_irq(cmd_irq), .cmd_data(cmd_data), .irq_in(irq_in), .core_irq(core_irq)
    );

    // Behavioural reference model
    int             m_dest [NI];
    bit             m_rr   [NI];
    bit             m_blk  [NI];
    int             m_ptr  [NI];
    bit             m_prev [NI];
    bit             m_en;
    logic [TOT-1:0] exp_out = '0;

    always @(posedge clk) begin
        logic [TOT-1:0] nxt;
        nxt = '0;
        if (rst) begin
            m_en = 0;
            for (int i = 0; i < NI; i++) begin
                m_dest[i] = 0; m_rr[i] = 1; m_blk[i] = 1; m_ptr[i] = 0; m_prev[i] = 0;
            end
        end else begin
            for (int i = 0; i < NI; i++) begin
                int start;
                int tgt;
                start = m_rr[i] ? m_ptr[i] : 0;
                tgt = -1;
                for (int k = 0; k < NC; k++) begin
                    int p;
                    p = (start + k) % NC;
                    if (tgt < 0 && m_dest[i][p]) tgt = p;
                end
                if (m_en && !m_blk[i] && irq_in[i] && tgt >= 0) nxt[tgt*NI + i] = 1'b1;
                if (m_rr[i] && m_prev[i] && !irq_in[i] && tgt >= 0) m_ptr[i] = (tgt + 1) % NC;
                m_prev[i] = irq_in[i];
            end
            if (cmd_valid) begin
                case (cmd_op)
                    2'd0: m_dest[cmd_irq] = int'(cmd_data[NC-1:0]);
                    2'd1: m_rr[cmd_irq]   = (cmd_data[1:0] == 2'b00);
                    2'd2: m_blk[cmd_irq]  = cmd_data[0];
                    default: m_en = cmd_data[0];
                endcase
            end
        end
        exp_out = nxt;
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (core_irq !== exp_out) begin
                fails++;
                $display("FAIL %s cycle %0d: core_irq=%h expected %h", cur_req, cycles, core_irq, exp_out);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] op, input int irq, input logic [31:0] data);
        cmd_valid = 1'b1; cmd_op = op; cmd_irq = IW'(irq); cmd_data = data;
        tick(1);
        cmd_valid = 1'b0; cmd_data = '0;
    endtask

    task automatic chk(input int c, input int i, input logic v, input string req);
        checks++;
        if (core_irq[c*NI + i] !== v) begin
            fails++;
            $display("FAIL %s line core%0d/irq%0d: got %b expected %b", req, c, i, core_irq[c*NI + i], v);
        end
    endtask

    task automatic chk_all(input logic [TOT-1:0] v, input string req);
        checks++;
        if (core_irq !== v) begin
            fails++;
            $display("FAIL %s: core_irq=%h expected %h", req, core_irq, v);
        end
    endtask

    task automatic pulse0();
        irq_in[0] = 1'b0; tick(2);
        irq_in[0] = 1'b1; tick(2);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk_all('0, "R1");

        // R1, R8: enabled and unblocked, mask still empty
        cur_req = "R8";
        cmd(2'd3, 0, 32'd1);
        cmd(2'd2, 0, 32'd0);
        irq_in[0] = 1'b1; tick(2);
        chk_all('0, "R8");

        // R2, R6: round robin over cores 1 and 2
        cur_req = "R6";
        cmd(2'd0, 0, 32'b0110); tick(1);
        chk(1, 0, 1'b1, "R2");
        tick(5);
        chk(1, 0, 1'b1, "R6");
        pulse0(); chk(2, 0, 1'b1, "R6");
        pulse0(); chk(1, 0, 1'b1, "R6");

        // R3: garbage in upper bits, select 00 keeps round-robin
        cur_req = "R3";
        cmd(2'd1, 0, 32'hFFFF_FFEC);
        pulse0(); chk(2, 0, 1'b1, "R3");

        // R7: fixed destination uses lowest set bit
        cur_req = "R7";
        cmd(2'd1, 0, 32'h0000_0011);
        pulse0(); chk(1, 0, 1'b1, "R7");
        pulse0(); chk(1, 0, 1'b1, "R7");

        // R4: block and unblock
        cur_req = "R4";
        cmd(2'd2, 0, 32'd1); tick(1);
        chk(1, 0, 1'b0, "R4");
        cmd(2'd2, 0, 32'd0); tick(1);
        chk(1, 0, 1'b1, "R4");

        cur_req = "R2";
        cmd(2'd0, 0, 32'b1000); tick(1);
        chk(3, 0, 1'b1, "R2");

        // R5: global off and on
        cur_req = "R5";
        cmd(2'd3, 0, 32'd0); tick(1);
        chk_all('0, "R5");
        cmd(2'd3, 0, 32'd1); tick(1);
        chk(3, 0, 1'b1, "R5");

        // R10: line 2 to core 3 lands on bit 14
        cur_req = "R10";
        irq_in[0] = 1'b0;
        cmd(2'd0, 2, 32'b1000);
        cmd(2'd1, 2, 32'd2);
        cmd(2'd2, 2, 32'd0);
        irq_in[2] = 1'b1; tick(2);
        chk_all(16'h4000, "R10");
        irq_in[2] = 1'b0; tick(2);

        // R9: mixed traffic with interleaved commands
        cur_req = "R9";
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] < 4'd3) begin
                irq_in = lfsr[7:4];
                cmd(lfsr[9:8], int'(lfsr[11:10]), {16'h0, lfsr});
            end else begin
                if (lfsr[14]) irq_in = lfsr[7:4];
                tick(1);
            end
        end
        tick(2);
        finish_run();
    end

endmodule